// File: doc/BRIEF.md
# Condition-Code ALU

This block is the combinational arithmetic/logic stage of a small 16-bit load/store core. One operation select picks among register-register logic and add, compare, short-immediate add and negate-add, byte-immediate logic and compare, and two byte moves. Besides the two register operands A and B, the block takes the current value of the destination register, called W. The byte-immediate operations read and merge W. The block also takes the raw 8-bit immediate field of the instruction and extends it internally. It returns the result word, a result write enable, a flag write enable and the four condition flags carry, negative, overflow and zero. The enclosing core owns the flag register and latches the flags only when the flag write enable is high.

All flags come from one shared 17-bit adder with inputs X and Y. For arithmetic operations X and Y are the operands. For logic operations X is the logic result and Y is zero. For compares Y is the two's-complement negation of the second operand. The logic operations therefore always clear carry and overflow. A compare against zero reports no carry.

The op_sel encoding is 0 OR, 1 ADD, 2 AND, 3 CMP, 4 ADDI, 5 NEGI, 6 ORI, 7 ANDI, 8 CMPI, 9 MOVI, 10 MOVIS. Codes 11 to 15 are reserved. The short immediate is imm_fld[4:0], sign-extended. The byte immediate is imm_fld[7:0]. Because the block is purely combinational, it has no handshake: outputs follow the inputs within the same cycle.

Top module: `alu_nzcv`

## Requirements
- R1: For every flag-setting operation with adder inputs X and Y and S = X + Y (17 bits), flag_c = S[16], flag_n = S[15], flag_z = (S[15:0] == 0), and flag_v = 1 exactly when X[15] == Y[15] and S[15] != X[15].
- R2: ADD (op 1) writes A + B modulo 2^16, with flags from X=A, Y=B.
- R3: OR (op 0) and AND (op 2) write A|B and A&B, with flags from X=result, Y=0, so flag_c and flag_v are 0.
- R4: ORI (op 6) writes W | zext(imm8), and ANDI (op 7) writes W & {8'hFF, imm8}. Both take their flags as in R3.
- R5: CMP (op 3) takes flags from X=A, Y=(~B)+1 and drives res_we=0 and result=0.
- R6: CMPI (op 8) takes flags from X=W, Y=(~sext(imm8))+1 and drives res_we=0 and result=0.
- R7: ADDI (op 4) writes A + sext(imm_fld[4:0]), with flags from X=A, Y=sext(imm_fld[4:0]).
- R8: NEGI (op 5) writes (~A) + sext(imm_fld[4:0]), with flags from X=~A, Y=sext(imm_fld[4:0]).
- R9: MOVI (op 9) writes zext(imm8), and MOVIS (op 10) writes {imm8, W[7:0]}. Both set res_we=1 and flag_we=0.
- R10: Reserved codes 11 to 15 drive result=0, res_we=0 and flag_we=0.
- R11: flag_we is 1 exactly for ops 0 to 8. Whenever flag_we is 0, all four flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation select (encoding above) |
| opnd_a | input | 16 | First register operand A |
| opnd_b | input | 16 | Second register operand B |
| opnd_w | input | 16 | Current destination register value W |
| imm_fld | input | 8 | Raw immediate field; bits 4:0 form the short immediate |
| result | output | 16 | Result word |
| res_we | output | 1 | Result should be written to the destination |
| flag_we | output | 1 | Flags should be latched |
| flag_c | output | 1 | Carry |
| flag_n | output | 1 | Negative |
| flag_v | output | 1 | Overflow |
| flag_z | output | 1 | Zero |

## Verification
The checker watches invariants that hold on every input combination. Compares never write. Logic operations never raise carry or overflow. Quiet flags read zero when flag_we is low. Reserved codes assert no enable. For logic operations, the zero and negative flags agree with the result word. Only the bench's sweeps can show the arithmetic itself: correct sums, sign extension of both immediate widths, the negations inside the compares, and the overflow and carry corners at 0x7FFF, 0x8000, 0xFFFF and 0x0000. The bench checks these against its own model over every operation and a grid of corner operands and immediates.

// File: rtl/alu_nzcv_pkg.sv
package alu_nzcv_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_OR    = 4'd0,
    OP_ADD   = 4'd1,
    OP_AND   = 4'd2,
    OP_CMP   = 4'd3,
    OP_ADDI  = 4'd4,
    OP_NEGI  = 4'd5,
    OP_ORI   = 4'd6,
    OP_ANDI  = 4'd7,
    OP_CMPI  = 4'd8,
    OP_MOVI  = 4'd9,
    OP_MOVIS = 4'd10
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic n;
    logic v;
    logic z;
  } nzcv_t;
endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
  parameter int W       = 16,
  parameter int SHORT_W = 5,
  parameter int BYTE_W  = 8
) (
  input  logic [BYTE_W-1:0] imm_fld,
  output logic [W-1:0]      short_sx,
  output logic [W-1:0]      byte_sx,
  output logic [W-1:0]      byte_zx,
  output logic [W-1:0]      byte_keep_hi,
  output logic [W-1:0]      byte_up
);
  localparam int SHORT_PAD = W - SHORT_W;
  localparam int BYTE_PAD  = W - BYTE_W;

  logic [SHORT_W-1:0] short_f;
  assign short_f = imm_fld[SHORT_W-1:0];

  assign short_sx     = {{SHORT_PAD{short_f[SHORT_W-1]}}, short_f};
  assign byte_sx      = {{BYTE_PAD{imm_fld[BYTE_W-1]}}, imm_fld};
  assign byte_zx      = {{BYTE_PAD{1'b0}}, imm_fld};
  assign byte_keep_hi = {{BYTE_PAD{1'b1}}, imm_fld};
  assign byte_up      = {imm_fld, {BYTE_PAD{1'b0}}};
endmodule

// File: rtl/alu_flag_add.sv
module alu_flag_add
  import alu_nzcv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] add_x,
  input  logic [W-1:0] add_y,
  output logic [W-1:0] sum_lo,
  output nzcv_t        flags
);
  logic [W:0] sum_full;

  assign sum_full = {1'b0, add_x} + {1'b0, add_y};
  assign sum_lo   = sum_full[W-1:0];

  always_comb begin
    flags.c = sum_full[W];
    flags.n = sum_full[W-1];
    flags.z = (sum_full[W-1:0] == '0);
    flags.v = (add_x[W-1] == add_y[W-1]) && (sum_full[W-1] != add_x[W-1]);
  end
endmodule

// File: rtl/alu_op_ctrl.sv
module alu_op_ctrl
  import alu_nzcv_pkg::*;
(
  input  alu_op_e op,
  output logic    res_we,
  output logic    flag_we,
  output logic    use_sum
);
  always_comb begin
    res_we  = 1'b0;
    flag_we = 1'b0;
    use_sum = 1'b0;
    case (op)
      OP_OR, OP_AND, OP_ORI, OP_ANDI: begin
        res_we  = 1'b1;
        flag_we = 1'b1;
      end
      OP_ADD, OP_ADDI, OP_NEGI: begin
        res_we  = 1'b1;
        flag_we = 1'b1;
        use_sum = 1'b1;
      end
      OP_CMP, OP_CMPI: flag_we = 1'b1;
      OP_MOVI, OP_MOVIS: res_we = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_nzcv.sv
module alu_nzcv
  import alu_nzcv_pkg::*;
#(
  parameter int W       = 16,
  parameter int SHORT_W = 5,
  parameter int BYTE_W  = 8
) (
  input  logic [3:0]        op_sel,
  input  logic [W-1:0]      opnd_a,
  input  logic [W-1:0]      opnd_b,
  input  logic [W-1:0]      opnd_w,
  input  logic [BYTE_W-1:0] imm_fld,
  output logic [W-1:0]      result,
  output logic              res_we,
  output logic              flag_we,
  output logic              flag_c,
  output logic              flag_n,
  output logic              flag_v,
  output logic              flag_z
);
  localparam logic [W-1:0] ONE      = W'(1);
  localparam logic [W-1:0] LOW_MASK = W'((1 << BYTE_W) - 1);

  alu_op_e     op;
  logic [W-1:0] short_sx, byte_sx, byte_zx, byte_keep_hi, byte_up;
  logic [W-1:0] add_x, add_y, sum_lo, logic_res;
  logic         use_sum, res_we_i, flag_we_i;
  nzcv_t        add_flags;

  assign op = alu_op_e'(op_sel);

  alu_imm_ext #(.W(W), .SHORT_W(SHORT_W), .BYTE_W(BYTE_W)) u_ext (
    .imm_fld      (imm_fld),
    .short_sx     (short_sx),
    .byte_sx      (byte_sx),
    .byte_zx      (byte_zx),
    .byte_keep_hi (byte_keep_hi),
    .byte_up      (byte_up)
  );

  alu_op_ctrl u_ctrl (
    .op      (op),
    .res_we  (res_we_i),
    .flag_we (flag_we_i),
    .use_sum (use_sum)
  );

  // Operand steering: logic results go through the adder with zero.
  always_comb begin
    logic_res = '0;
    add_x     = '0;
    add_y     = '0;
    case (op)
      OP_OR:    logic_res = opnd_a | opnd_b;
      OP_AND:   logic_res = opnd_a & opnd_b;
      OP_ORI:   logic_res = opnd_w | byte_zx;
      OP_ANDI:  logic_res = opnd_w & byte_keep_hi;
      OP_MOVI:  logic_res = byte_zx;
      OP_MOVIS: logic_res = (opnd_w & LOW_MASK) | byte_up;
      default:  logic_res = '0;
    endcase
    case (op)
      OP_ADD:  begin add_x = opnd_a;  add_y = opnd_b; end
      OP_ADDI: begin add_x = opnd_a;  add_y = short_sx; end
      OP_NEGI: begin add_x = ~opnd_a; add_y = short_sx; end
      OP_CMP:  begin add_x = opnd_a;  add_y = (~opnd_b) + ONE; end
      OP_CMPI: begin add_x = opnd_w;  add_y = (~byte_sx) + ONE; end
      default: begin add_x = logic_res; add_y = '0; end
    endcase
  end

  alu_flag_add #(.W(W)) u_add (
    .add_x  (add_x),
    .add_y  (add_y),
    .sum_lo (sum_lo),
    .flags  (add_flags)
  );

  assign res_we  = res_we_i;
  assign flag_we = flag_we_i;
  assign result  = !res_we_i ? '0 : (use_sum ? sum_lo : logic_res);
  assign flag_c  = flag_we_i & add_flags.c;
  assign flag_n  = flag_we_i & add_flags.n;
  assign flag_v  = flag_we_i & add_flags.v;
  assign flag_z  = flag_we_i & add_flags.z;
endmodule

// File: rtl/alu_nzcv_chk.sv
module alu_nzcv_chk #(
  parameter int W = 16
) (
  input logic [3:0]   op_sel,
  input logic [W-1:0] result,
  input logic         res_we,
  input logic         flag_we,
  input logic         flag_c,
  input logic         flag_n,
  input logic         flag_v,
  input logic         flag_z
);
  logic is_logic;
  assign is_logic = (op_sel == 4'd0) || (op_sel == 4'd2) ||
                    (op_sel == 4'd6) || (op_sel == 4'd7);

  always_comb begin
    if (op_sel == 4'd3 || op_sel == 4'd8)
      a_r5_cmp_no_write: assert (!res_we && result == '0);
    if (is_logic)
      a_r3_logic_cv_clear: assert (!flag_c && !flag_v);
    if (is_logic)
      a_r1_logic_nz_track: assert (flag_z == (result == '0) && flag_n == result[W-1]);
    if (!flag_we)
      a_r11_flags_quiet: assert (!flag_c && !flag_n && !flag_v && !flag_z);
    if (op_sel > 4'd10)
      a_r10_reserved_idle: assert (!res_we && !flag_we && result == '0);
  end
endmodule

bind alu_nzcv alu_nzcv_chk #(.W(W)) u_chk (
  .op_sel  (op_sel),
  .result  (result),
  .res_we  (res_we),
  .flag_we (flag_we),
  .flag_c  (flag_c),
  .flag_n  (flag_n),
  .flag_v  (flag_v),
  .flag_z  (flag_z)
);

// File: tb/tb_alu_nzcv.sv
module tb_alu_nzcv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [15:0] opnd_a = '0, opnd_b = '0, opnd_w = '0;
  logic [7:0]  imm_fld = '0;
  logic [15:0] result;
  logic        res_we, flag_we, flag_c, flag_n, flag_v, flag_z;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu_nzcv dut (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_w(opnd_w),
    .imm_fld(imm_fld), .result(result), .res_we(res_we), .flag_we(flag_we),
    .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z)
  );

  // expected vector: {result, res_we, flag_we, c, n, v, z}
  function automatic logic [21:0] model(input logic [3:0] op, input logic [15:0] a,
      input logic [15:0] b, input logic [15:0] w, input logic [7:0] im);
    logic [15:0] s5, s8, x, y, r;
    logic [16:0] s;
    logic rw, fw, c, n, v, z;
    s5 = {{11{im[4]}}, im[4:0]};
    s8 = {{8{im[7]}}, im};
    x = 0; y = 0; r = 0; rw = 1; fw = 1;
    case (op)
      0: begin r = a | b; x = r; end
      1: begin x = a; y = b; end
      2: begin r = a & b; x = r; end
      3: begin x = a; y = 16'(0 - int'(b)); rw = 0; end
      4: begin x = a; y = s5; end
      5: begin x = ~a; y = s5; end
      6: begin r = w | {8'h00, im}; x = r; end
      7: begin r = w & {8'hFF, im}; x = r; end
      8: begin x = w; y = 16'(0 - int'(s8)); rw = 0; end
      9: begin r = {8'h00, im}; fw = 0; end
      10: begin r = {im, w[7:0]}; fw = 0; end
      default: begin rw = 0; fw = 0; end
    endcase
    s = {1'b0, x} + {1'b0, y};
    if (op == 1 || op == 4 || op == 5) r = s[15:0];
    c = s[16]; n = s[15]; z = (s[15:0] == 0);
    v = (x[15] == y[15]) && (s[15] != x[15]);
    if (!fw) {c, n, v, z} = 4'b0;
    return {r, rw, fw, c, n, v, z};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      0, 2: return "R3";
      1: return "R2";
      3: return "R5";
      4: return "R7";
      5: return "R8";
      6, 7: return "R4";
      8: return "R6";
      9, 10: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic compare(input string tag, input logic [21:0] exp);
    logic [21:0] act;
    act = {result, res_we, flag_we, flag_c, flag_n, flag_v, flag_z};
    checks++;
    if (act[21:4] != exp[21:4]) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h w=%h imm=%h: result/we act=%h exp=%h",
               tag, op_sel, opnd_a, opnd_b, opnd_w, imm_fld, act[21:4], exp[21:4]);
    end
    checks++;
    if (act[3:0] != exp[3:0]) begin
      errors++;
      $display("FAIL %s/R1 op=%0d a=%h b=%h w=%h imm=%h: cnvz act=%b exp=%b",
               tag, op_sel, opnd_a, opnd_b, opnd_w, imm_fld, act[3:0], exp[3:0]);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] w, input logic [7:0] im);
    @(posedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; opnd_w = w; imm_fld = im;
    @(negedge clk);
  endtask

  task automatic directed(input string tag, input logic [3:0] op, input logic [15:0] a,
      input logic [15:0] b, input logic [15:0] w, input logic [7:0] im, input logic [21:0] exp);
    apply(op, a, b, w, im);
    compare(tag, exp);
  endtask

  logic [15:0] corner [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                              16'hFFFF, 16'h5555, 16'h00FF, 16'h8001};
  logic [7:0]  imms   [8] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h1F, 8'h7F, 8'h80, 8'hFF};

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R10: idle/reserved state at start
    directed("R10", 4'd15, 16'hFFFF, 16'hFFFF, 16'hFFFF, 8'hFF, {16'h0, 6'b0});
    // R1: signed overflow into negative
    directed("R1", 4'd1, 16'h7FFF, 16'h0001, 16'h0, 8'h0, {16'h8000, 2'b11, 4'b0110});
    // R1: carry out with zero result
    directed("R1", 4'd1, 16'hFFFF, 16'h0001, 16'h0, 8'h0, {16'h0000, 2'b11, 4'b1001});
    // R5: equal operands give Z and C
    directed("R5", 4'd3, 16'h0005, 16'h0005, 16'h0, 8'h0, {16'h0000, 2'b01, 4'b1001});
    // R5: compare zero with zero gives no carry
    directed("R5", 4'd3, 16'h0000, 16'h0000, 16'h0, 8'h0, {16'h0000, 2'b01, 4'b0001});
    // R6: 0x8000 minus 1 overflows
    directed("R6", 4'd8, 16'h0, 16'h0, 16'h8000, 8'h01, {16'h0000, 2'b01, 4'b1010});
    // R4: ANDI keeps upper byte
    directed("R4", 4'd7, 16'h0, 16'h0, 16'h1234, 8'h0F, {16'h1204, 2'b11, 4'b0000});
    // R9: MOVIS keeps low byte, no flags
    directed("R9", 4'd10, 16'h0, 16'h0, 16'h1234, 8'hAB, {16'hAB34, 2'b10, 4'b0000});
    // R8: ~0 + 1 wraps to zero with carry
    directed("R8", 4'd5, 16'h0000, 16'h0, 16'h0, 8'h01, {16'h0000, 2'b11, 4'b1001});
    // R11: MOVI raises no flag enable
    directed("R11", 4'd9, 16'hFFFF, 16'hFFFF, 16'hFFFF, 8'h80, {16'h0080, 2'b10, 4'b0000});

    // Sweep every op over corner operands and immediates (R1..R11)
    for (int op = 0; op < 16; op++)
      for (int ia = 0; ia < 8; ia++)
        for (int ib = 0; ib < 8; ib++)
          for (int ii = 0; ii < 8; ii++) begin
            apply(4'(op), corner[ia], corner[ib], corner[(ia + ib + ii) % 8], imms[ii]);
            compare(tag_of(4'(op)), model(4'(op), corner[ia], corner[ib],
                    corner[(ia + ib + ii) % 8], imms[ii]));
          end

    // Pseudo-random operands
    begin
      logic [31:0] lfsr;
      lfsr = 32'h1ACE_B00C;
      for (int k = 0; k < 3000; k++) begin
        logic [15:0] ra, rb, rw2;
        lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
        ra = lfsr[15:0]; rb = lfsr[31:16];
        rw2 = ra ^ {rb[7:0], rb[15:8]};
        apply(4'(k % 11), ra, rb, rw2, lfsr[23:16]);
        compare(tag_of(4'(k % 11)), model(4'(k % 11), ra, rb, rw2, lfsr[23:16]));
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: act=timeout exp=completion");
      end
    join_any
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule